// File: doc/BRIEF.md
# Watermark-driven DMA burst engine

This block is the bus-master side of a packet DMA. It moves one host buffer per job between a local FIFO and memory over a 32-bit multiplexed address/data bus with active-low control strobes. A receive job drains the receive FIFO into memory with write bursts. A transmit job reads memory into the transmit FIFO.

A job is started with a buffer address, a byte length and a direction. The engine then requests the bus whenever its FIFO can justify a burst. Each burst has one address phase followed by full-DWord data phases. Byte enables mask the lanes outside the buffer, so buffers may start and end on any byte.

A burst ends in one of three ways: the FIFO reaches its watermark, the buffer ends, or the grant has been withdrawn and the latency timer has run out. After a burst that leaves bytes outstanding, the job waits and resumes at the next DWord address. A running count of moved bytes reports the exact buffer length, not a DWord-rounded figure.

Top module: `dma_burst_engine`

## Requirements
- R1: After reset, req_n, frame_n and irdy_n are high, ad_oe is low, done and aborted are low, and moved_bytes is zero.
- R2: Each burst begins with one address phase: frame_n low, irdy_n high, ad_out holding the current address with bits 1:0 cleared, and cbe_n equal to 0111 for a receive job (dir=0, memory write) or 0110 for a transmit job (dir=1, memory read). The first data phase follows on the next clock.
- R3: Every data phase is a full DWord. cbe_n is active low with bit i covering byte lane i (bits 7:0 are lane 0). The enabled lanes run from the address offset up to the buffer end or lane 3, whichever comes first. Examples: lane 0 only is 1110, lane 3 only is 0111, lanes 2-3 are 0011, lanes 1-3 are 0001, lanes 0-2 are 1000.
- R4: A receive burst starts only when rxf_level exceeds rx_low_wm, or when the FIFO already holds every DWord the rest of the buffer needs. The phase taken while rxf_level is at most rx_low_wm+1 is the last one, except in the case where the FIFO holds the rest of the buffer.
- R5: A transmit burst starts only when txf_level is below tx_high_wm. The phase taken while txf_level+1 reaches tx_high_wm is the last one.
- R6: The phase that carries the final buffer byte ends the burst. done then pulses for one cycle, and moved_bytes equals the exact number of buffer bytes moved.
- R7: On the final data phase of a burst, frame_n and req_n are already high. irdy_n goes high on the clock after that phase completes.
- R8: The latency timer loads lat_timer_val at the address phase and counts down once per clock to zero. With gnt_n high, the burst continues until the timer reaches zero and ends on that phase. A withdrawn grant does not shorten a burst while the timer is non-zero.
- R9: If devsel_n stays high for DEVSEL_TO data-phase clocks, the burst is abandoned with no data moved, and done and aborted pulse together.
- R10: Data moves only in clocks where irdy_n and trdy_n are both low and the target has claimed the cycle. FIFO levels are re-read on every phase, so data that arrives during target wait states can lengthen a burst.
- R11: During receive data phases, ad_oe is high and ad_out carries rxf_data unchanged. During transmit data phases, each completed phase pushes exactly one DWord from ad_in into the transmit FIFO.
- R12: A later burst of the same job starts at the DWord address after the last phase moved, and moved_bytes keeps counting from the earlier bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a job (accepted when idle) |
| dir | input | 1 | 0 receive (memory write), 1 transmit (memory read) |
| buf_addr | input | 32 | Buffer byte address |
| buf_len | input | LEN_W | Buffer length in bytes |
| lat_timer_val | input | TMR_W | Latency timer reload value |
| rx_low_wm | input | LVL_W | Receive FIFO low watermark, DWords |
| tx_high_wm | input | LVL_W | Transmit FIFO high watermark, DWords |
| rxf_level | input | LVL_W | Receive FIFO fill, DWords |
| rxf_data | input | 32 | Receive FIFO head word |
| rxf_pop | output | 1 | Receive FIFO pop |
| txf_level | input | LVL_W | Transmit FIFO fill, DWords |
| txf_push | output | 1 | Transmit FIFO push |
| txf_wdata | output | 32 | Transmit FIFO write word |
| req_n | output | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| frame_n | output | 1 | Transaction frame, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Target claim, active low |
| ad_out | output | 32 | Driven address/data |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 32 | Received data |
| cbe_n | output | 4 | Command in address phase, byte enables in data phases |
| done | output | 1 | Job finished (pulse) |
| aborted | output | 1 | Job ended with no target claim (pulse) |
| moved_bytes | output | LEN_W | Exact bytes moved in this job |

## Verification
A table of buffers drives the main burst path and compares the phase count, the first and last byte-enable patterns, the exact byte count and the done pulse. The entries cover aligned long buffers stopped by a watermark, offsets 1, 2 and 3 at the start, short tails of one and three bytes, and FIFOs that sit exactly on the watermark and so must not request at all. Together these separate watermark ends from buffer ends and from the flush case. Directed runs then withdraw the grant with a short and a long latency timer, which separates a preemption end from a watermark end. Further runs leave devsel_n high, toggle trdy_n with and without the FIFO filling, and resume a stalled receive job to confirm that it continues at the next DWord address.

// File: rtl/dma_burst_engine.sv
module dma_burst_engine #(
  parameter int LVL_W     = 6,
  parameter int LEN_W     = 16,
  parameter int TMR_W     = 8,
  parameter int DEVSEL_TO = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir,
  input  logic [31:0]      buf_addr,
  input  logic [LEN_W-1:0] buf_len,
  input  logic [TMR_W-1:0] lat_timer_val,
  input  logic [LVL_W-1:0] rx_low_wm,
  input  logic [LVL_W-1:0] tx_high_wm,
  input  logic [LVL_W-1:0] rxf_level,
  input  logic [31:0]      rxf_data,
  output logic             rxf_pop,
  input  logic [LVL_W-1:0] txf_level,
  output logic             txf_push,
  output logic [31:0]      txf_wdata,
  output logic             req_n,
  input  logic             gnt_n,
  output logic             frame_n,
  output logic             irdy_n,
  input  logic             trdy_n,
  input  logic             devsel_n,
  output logic [31:0]      ad_out,
  output logic             ad_oe,
  input  logic [31:0]      ad_in,
  output logic [3:0]       cbe_n,
  output logic             done,
  output logic             aborted,
  output logic [LEN_W-1:0] moved_bytes
);

  localparam int DC_W = $clog2(DEVSEL_TO + 1);
  localparam int NW   = LEN_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_ADDR, S_DATA, S_TURN} st_t;

  st_t              st;
  logic             dir_q, final_q, claimed_q, abort_q;
  logic [31:0]      addr_q;
  logic [LEN_W-1:0] rem_q, moved_q;
  logic [TMR_W-1:0] tmr_q;
  logic [DC_W-1:0]  dcnt_q;

  logic [1:0]    off;
  logic [2:0]    room, n_this;
  logic [NW-1:0] need_dw;
  logic          flush, buf_last, wm_last, pre_last, last_now;
  logic          go_ok, dv_ok, dv_to, xfer, in_data, streaming;
  logic [3:0]    be_n;

  assign off      = addr_q[1:0];
  assign room     = 3'd4 - {1'b0, off};
  assign n_this   = (rem_q < LEN_W'(room)) ? rem_q[2:0] : room;
  assign need_dw  = ({1'b0, rem_q} + NW'(off) + NW'(3)) >> 2;
  assign flush    = NW'(rxf_level) >= need_dw;
  assign buf_last = rem_q <= LEN_W'(room);
  assign wm_last  = dir_q ? ({1'b0, txf_level} + 1'b1 >= {1'b0, tx_high_wm})
                          : (!flush && ({1'b0, rxf_level} <= {1'b0, rx_low_wm} + 1'b1));
  assign pre_last = gnt_n && (tmr_q == '0);
  assign last_now = final_q || buf_last || wm_last || pre_last;

  assign go_ok = (rem_q != '0) &&
                 (dir_q ? (txf_level < tx_high_wm)
                        : ((rxf_level > rx_low_wm) || ((rxf_level != '0) && flush)));

  assign in_data   = (st == S_DATA);
  assign dv_ok     = claimed_q || !devsel_n;
  assign dv_to     = in_data && !dv_ok && (dcnt_q == DC_W'(DEVSEL_TO - 1));
  assign xfer      = in_data && !trdy_n && dv_ok;
  assign streaming = in_data && !last_now && !dv_to;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      be_n[i] = !((3'(i) >= {1'b0, off}) && (3'(i) < {1'b0, off} + n_this));
    end
  end

  assign req_n     = !((st == S_WAIT && go_ok) || st == S_ADDR || streaming);
  assign frame_n   = !(st == S_ADDR || streaming);
  assign irdy_n    = !in_data;
  assign ad_oe     = (st == S_ADDR) || (in_data && !dir_q);
  assign ad_out    = (st == S_ADDR) ? {addr_q[31:2], 2'b00} : rxf_data;
  assign cbe_n     = (st == S_ADDR) ? (dir_q ? 4'b0110 : 4'b0111) : (in_data ? be_n : 4'b1111);
  assign rxf_pop   = xfer && !dir_q;
  assign txf_push  = xfer && dir_q;
  assign txf_wdata = ad_in;
  assign done      = (st == S_TURN) && ((rem_q == '0) || abort_q);
  assign aborted   = (st == S_TURN) && abort_q;
  assign moved_bytes = moved_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      dir_q     <= 1'b0;
      final_q   <= 1'b0;
      claimed_q <= 1'b0;
      abort_q   <= 1'b0;
      addr_q    <= '0;
      rem_q     <= '0;
      moved_q   <= '0;
      tmr_q     <= '0;
      dcnt_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          dir_q   <= dir;
          addr_q  <= buf_addr;
          rem_q   <= buf_len;
          moved_q <= '0;
          abort_q <= 1'b0;
          st      <= S_WAIT;
        end
        S_WAIT: begin
          if (rem_q == '0)        st <= S_TURN;
          else if (go_ok && !gnt_n) st <= S_ADDR;
        end
        S_ADDR: begin
          tmr_q     <= lat_timer_val;
          final_q   <= 1'b0;
          claimed_q <= 1'b0;
          dcnt_q    <= '0;
          abort_q   <= 1'b0;
          st        <= S_DATA;
        end
        S_DATA: begin
          if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
          if (!devsel_n) claimed_q <= 1'b1;
          else if (!claimed_q) dcnt_q <= dcnt_q + 1'b1;
          final_q <= last_now;
          if (dv_to) begin
            abort_q <= 1'b1;
            st      <= S_TURN;
          end else if (xfer) begin
            addr_q  <= {addr_q[31:2] + 30'd1, 2'b00};
            rem_q   <= rem_q - LEN_W'(n_this);
            moved_q <= moved_q + LEN_W'(n_this);
            if (last_now) st <= S_TURN;
          end
        end
        S_TURN: st <= (abort_q || rem_q == '0) ? S_IDLE : S_WAIT;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && irdy_n) |=> !irdy_n); // R2
  AST_BE_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !irdy_n |-> (cbe_n != 4'b1111)); // R3
  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_pop |-> (rxf_level != '0)); // R4
  AST_FINAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !trdy_n && dv_ok && frame_n) |=> irdy_n); // R7
  AST_FRAME_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && frame_n) |=> frame_n); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_ABORT_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> (req_n && frame_n && irdy_n && done)); // R9

endmodule

// File: tb/dma_burst_engine_tb_top.sv
module dma_burst_engine_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, start = 1'b0, dir = 1'b0;
  logic [31:0] buf_addr = '0;
  logic [15:0] buf_len = '0;
  logic [7:0]  lat_val = 8'd255;
  logic [5:0]  rx_wm = '0, tx_wm = '0;
  logic [5:0]  rx_lvl = '0, tx_lvl = '0;
  logic        rxf_pop, txf_push, req_n, frame_n, irdy_n, ad_oe, done, aborted;
  logic [31:0] txf_wdata, ad_out, rxf_data;
  logic [3:0]  cbe_n;
  logic [15:0] moved;
  logic        gnt_n, trdy_n, devsel_n;

  logic tgt_en = 1'b1, slow = 1'b0, inc_en = 1'b0, drop_gnt = 1'b0;
  logic tgl = 1'b0, gnt_drop_q = 1'b0;
  logic lv_ld = 1'b0, mon_clr = 1'b0;
  logic [5:0] ld_rx = '0, ld_tx = '0;

  assign rxf_data = {8'hA5, 2'b00, rx_lvl, 8'h3C, 2'b11, ~rx_lvl};
  assign trdy_n   = slow & tgl;
  assign devsel_n = ~tgt_en;
  assign gnt_n    = gnt_drop_q;

  dma_burst_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .buf_addr(buf_addr),
    .buf_len(buf_len), .lat_timer_val(lat_val), .rx_low_wm(rx_wm), .tx_high_wm(tx_wm),
    .rxf_level(rx_lvl), .rxf_data(rxf_data), .rxf_pop(rxf_pop), .txf_level(tx_lvl),
    .txf_push(txf_push), .txf_wdata(txf_wdata), .req_n(req_n), .gnt_n(gnt_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .devsel_n(devsel_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(32'h5EED_0000 | {26'd0, tx_lvl}),
    .cbe_n(cbe_n), .done(done), .aborted(aborted), .moved_bytes(moved));

  always @(posedge clk) begin
    tgl <= ~tgl;
    if (lv_ld) begin
      rx_lvl <= ld_rx;
      tx_lvl <= ld_tx;
    end else begin
      rx_lvl <= rx_lvl - {5'd0, rxf_pop} + {5'd0, inc_en};
      tx_lvl <= tx_lvl + {5'd0, txf_push};
    end
  end

  int nph, naddr;
  logic [3:0] first_be, last_be, cmd_seen;
  logic [31:0] addr_seen;
  logic done_seen, abort_seen, req_seen, data_bad, last_frame, last_req;

  always @(negedge clk) begin
    if (mon_clr) begin
      nph = 0; naddr = 0; first_be = 4'hF; last_be = 4'hF; cmd_seen = 4'hF;
      addr_seen = '0; done_seen = 0; abort_seen = 0; req_seen = 0; data_bad = 0;
      last_frame = 0; last_req = 0; gnt_drop_q <= 1'b0;
    end else begin
      if (!req_n) req_seen = 1;
      if (done) done_seen = 1;
      if (aborted) abort_seen = 1;
      if (!frame_n && irdy_n) begin
        naddr++; addr_seen = ad_out; cmd_seen = cbe_n;
        if (drop_gnt) gnt_drop_q <= 1'b1;
      end
      if (!irdy_n && !trdy_n && !devsel_n) begin
        nph++;
        if (nph == 1) first_be = cbe_n;
        last_be = cbe_n; last_frame = frame_n; last_req = req_n;
        if (!dir && (!ad_oe || ad_out != rxf_data)) data_bad = 1;
      end
    end
  end

  int errors = 0, checks = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 40000) begin
      errors++; checks++;
      $display("FAIL watchdog (all requirements): actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mon();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
  endtask

  task automatic set_lv(input logic [5:0] r, input logic [5:0] t);
    @(negedge clk); ld_rx = r; ld_tx = t; lv_ld = 1'b1;
    @(negedge clk); lv_ld = 1'b0;
  endtask

  task automatic job(input logic d, input logic [31:0] a, input logic [15:0] l,
                     input logic [5:0] lvl, input logic [5:0] wm);
    @(negedge clk); rst_n = 1'b0;
    dir = d; buf_addr = a; buf_len = l;
    if (d) begin tx_wm = wm; rx_wm = 6'd0; end else begin rx_wm = wm; tx_wm = 6'd63; end
    set_lv(d ? 6'd0 : lvl, d ? lvl : 6'd0);
    clear_mon();
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  typedef struct packed {
    logic dir; logic [31:0] addr; logic [15:0] len; logic [5:0] lvl; logic [5:0] wm;
    logic [7:0] ph; logic [3:0] fbe; logic [3:0] lbe; logic [15:0] bytes; logic dn;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{1'b0, 32'h1000, 16'd64, 6'd8, 6'd2, 8'd6, 4'b0000, 4'b0000, 16'd24, 1'b0},
    '{1'b0, 32'h1001, 16'd64, 6'd8, 6'd4, 8'd4, 4'b0001, 4'b0000, 16'd15, 1'b0},
    '{1'b0, 32'h2000, 16'd5,  6'd4, 6'd2, 8'd2, 4'b0000, 4'b1110, 16'd5,  1'b1},
    '{1'b0, 32'h2003, 16'd2,  6'd2, 6'd0, 8'd2, 4'b0111, 4'b1110, 16'd2,  1'b1},
    '{1'b0, 32'h3002, 16'd2,  6'd1, 6'd0, 8'd1, 4'b0011, 4'b0011, 16'd2,  1'b1},
    '{1'b1, 32'h4000, 16'd64, 6'd2, 6'd7, 8'd5, 4'b0000, 4'b0000, 16'd20, 1'b0},
    '{1'b1, 32'h4002, 16'd9,  6'd0, 6'd16,8'd3, 4'b0011, 4'b1000, 16'd9,  1'b1},
    '{1'b0, 32'h5000, 16'd64, 6'd2, 6'd2, 8'd0, 4'b1111, 4'b1111, 16'd0,  1'b0},
    '{1'b1, 32'h6000, 16'd64, 6'd7, 6'd7, 8'd0, 4'b1111, 4'b1111, 16'd0,  1'b0}
  };

  initial begin
    clear_mon();
    wait_cyc(2);
    chk(req_n && frame_n && irdy_n, "R1 strobes idle", {req_n, frame_n, irdy_n}, 3'b111);
    chk(!ad_oe && !done && !aborted, "R1 outputs quiet", {ad_oe, done, aborted}, 0);
    chk(moved == 0, "R1 moved_bytes", moved, 0);
    rst_n = 1'b1;

    foreach (VEC[k]) begin
      vec_t v = VEC[k];
      job(v.dir, v.addr, v.len, v.lvl, v.wm);
      wait_cyc(60);
      chk(nph == int'(v.ph), v.dir ? "R5 phase count" : "R4 phase count", nph, v.ph);
      chk(first_be == v.fbe, "R3 first byte enables", first_be, v.fbe);
      chk(last_be == v.lbe, "R3 last byte enables", last_be, v.lbe);
      chk(moved == v.bytes, "R6 exact byte count", moved, v.bytes);
      chk(done_seen == v.dn, "R6 done pulse", done_seen, v.dn);
      chk(naddr == ((v.ph != 0) ? 1 : 0), "R2 address phase count", naddr, (v.ph != 0) ? 1 : 0);
      if (v.ph != 0) begin
        chk(addr_seen == {v.addr[31:2], 2'b00}, "R2 address", addr_seen, {v.addr[31:2], 2'b00});
        chk(cmd_seen == (v.dir ? 4'b0110 : 4'b0111), "R2 command", cmd_seen, v.dir ? 4'b0110 : 4'b0111);
        chk(last_frame && last_req, "R7 frame and req high on final phase", {last_frame, last_req}, 2'b11);
        if (v.dir) chk(tx_lvl == v.lvl + v.ph[5:0], "R11 one push per read phase", tx_lvl, v.lvl + v.ph[5:0]);
        else chk(!data_bad, "R11 write data on AD", data_bad, 0);
      end else begin
        chk(!req_seen, v.dir ? "R5 no request at watermark" : "R4 no request at watermark", req_seen, 0);
      end
    end

    drop_gnt = 1'b1; lat_val = 8'd3;
    job(1'b0, 32'h7000, 16'd128, 6'd16, 6'd0);
    wait_cyc(40);
    chk(nph == 4, "R8 preempted burst ends at timer expiry", nph, 4);
    chk(last_frame, "R8 frame off on preempted final phase", last_frame, 1);

    lat_val = 8'd200;
    job(1'b0, 32'h7100, 16'd128, 6'd6, 6'd0);
    wait_cyc(40);
    chk(nph == 6, "R8 grant loss ignored while timer runs", nph, 6);
    drop_gnt = 1'b0; lat_val = 8'd255;

    tgt_en = 1'b0;
    job(1'b0, 32'h7200, 16'd64, 6'd8, 6'd0);
    wait_cyc(30);
    chk(abort_seen && done_seen, "R9 aborted and done", {abort_seen, done_seen}, 2'b11);
    chk(nph == 0 && moved == 0, "R9 nothing moved", moved, 0);
    chk(rx_lvl == 6'd8, "R9 no pops", rx_lvl, 8);
    tgt_en = 1'b1;

    slow = 1'b1;
    job(1'b0, 32'h7300, 16'd64, 6'd4, 6'd2);
    wait_cyc(60);
    chk(nph == 2, "R10 wait states alone do not lengthen", nph, 2);
    inc_en = 1'b1;
    job(1'b0, 32'h7400, 16'd64, 6'd4, 6'd2);
    wait_cyc(90);
    inc_en = 1'b0;
    chk(nph == 16, "R10 arrivals during waits lengthen burst", nph, 16);
    chk(moved == 16'd64 && done_seen, "R10 whole buffer moved", moved, 64);
    slow = 1'b0;

    job(1'b0, 32'h8000, 16'd64, 6'd4, 6'd2);
    wait_cyc(30);
    chk(nph == 2, "R12 first burst length", nph, 2);
    clear_mon();
    set_lv(6'd10, 6'd0);
    wait_cyc(60);
    chk(addr_seen == 32'h8008, "R12 resume address", addr_seen, 32'h8008);
    chk(nph == 8, "R12 second burst length", nph, 8);
    chk(moved == 16'd40, "R12 cumulative byte count", moved, 40);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule